// File: doc/BRIEF.md
# Byte-Wide Access Bridge for a 16-Bit Counter

This block sits between an 8-bit register bus and a 16-bit counter with a 16-bit reload value. It lets software move whole 16-bit values over the narrow bus without tearing. A single 8-bit holding byte serves both directions. On the write path, software writes the low half first. That byte waits in the holding byte until the high half is written. The two halves then reach the reload value together.

On the read path, reading the high half returns the counter's upper byte. In the same cycle, the counter's lower byte is captured into the holding byte. A later low-half read returns that captured byte, so both halves come from one instant. While the high half is being read, a hold output tells the counter to stop advancing. The reload output carries a one-cycle strobe each time it is updated, so the counter can decide how to apply the new value.

Top module: `ctr_byte_bridge`

## Requirements
- R1: After reset the holding byte is 00h, the reload output is 0000h and the reload strobe is low.
- R2: A write to the low-half address (`ADDR_LO`, default 0) stores the bus byte in the holding byte only. The reload output does not change and no strobe is issued.
- R3: A write to the high-half address (`ADDR_HI`, default 1) sets the reload output, from the next clock edge, to {written byte, holding byte}. `reload_we` is high for exactly that one cycle per write.
- R4: The reload output changes only as the result of a high-half write.
- R5: During a high-half read, `bus_rdata` equals `cnt_value[15:8]` in the same cycle. At that cycle's clock edge, `cnt_value[7:0]` is copied into the holding byte.
- R6: A low-half read returns the holding byte, never the live counter low byte. Without a prior high-half read, this is whatever was last written or captured, or 00h after reset.
- R7: `cnt_hold` is high in exactly those cycles in which a high-half read is performed.
- R8: When `bus_wr` and `bus_rd` are both high, only the write is performed. The read is ignored: `bus_rdata` is 00h and `cnt_hold` stays low.
- R9: An access to any other address has no effect on the holding byte or the reload output. It returns 00h.
- R10: The holding byte is shared between the paths. A high-half write that follows a high-half read with no low-half write in between loads the captured counter low byte into the reload low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| cnt_value | input | 16 | Live counter value |
| reload_val | output | 16 | Reload value for the counter |
| reload_we | output | 1 | One-cycle pulse when reload_val is updated |
| cnt_hold | output | 1 | Counter clock block during a high-half read |

## Verification
The bench checks that a low-half write leaves the reload value alone. A design that committed it early would show a half-updated reload value. It checks that a low-half read after a high-half read returns the captured byte while the live counter has moved on. A design that passed the counter through would return a torn value. Simultaneous read and write, out-of-range addresses, and back-to-back high writes are driven to catch a stray hold pulse, a corrupted holding byte or a missing strobe. Read-then-write sequences confirm that the captured byte feeds the next reload.

// File: rtl/ctr_byte_bridge_pkg.sv
package ctr_byte_bridge_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_WR_LO,
        ACC_WR_HI,
        ACC_RD_LO,
        ACC_RD_HI
    } acc_e;

    // Write has priority over read; unmatched addresses do nothing.
    function automatic acc_e classify(logic wr, logic rd, logic hit_lo, logic hit_hi);
        acc_e a;
        a = ACC_IDLE;
        if (wr) begin
            if (hit_hi)      a = ACC_WR_HI;
            else if (hit_lo) a = ACC_WR_LO;
        end else if (rd) begin
            if (hit_hi)      a = ACC_RD_HI;
            else if (hit_lo) a = ACC_RD_LO;
        end
        return a;
    endfunction
endpackage

// File: rtl/ctr_bridge_decode.sv
module ctr_bridge_decode
    import ctr_byte_bridge_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int ADDR_LO = 0,
    parameter int ADDR_HI = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_e              acc
);
    logic hit_lo, hit_hi;
    assign hit_lo = (addr == ADDR_W'(ADDR_LO));
    assign hit_hi = (addr == ADDR_W'(ADDR_HI));
    assign acc    = classify(wr, rd, hit_lo, hit_hi);
endmodule

// File: rtl/ctr_bridge_holdbyte.sv
module ctr_bridge_holdbyte
    import ctr_byte_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] hold_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            case (acc)
                ACC_WR_LO: hold_q <= wdata;
                ACC_RD_HI: hold_q <= cnt_lo;
                default:   hold_q <= hold_q;
            endcase
        end
    end
endmodule

// File: rtl/ctr_bridge_reload.sv
module ctr_bridge_reload
    import ctr_byte_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] hold_q,
    output logic [WORD_W-1:0] reload_q,
    output logic              reload_we
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q  <= '0;
            reload_we <= 1'b0;
        end else begin
            reload_we <= (acc == ACC_WR_HI);
            if (acc == ACC_WR_HI)
                reload_q <= {wdata, hold_q};
        end
    end
endmodule

// File: rtl/ctr_byte_bridge.sv
module ctr_byte_bridge
    import ctr_byte_bridge_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int ADDR_LO = 0,
    parameter int ADDR_HI = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic [WORD_W-1:0]     cnt_value,
    output logic [WORD_W-1:0]     reload_val,
    output logic                  reload_we,
    output logic                  cnt_hold
);
    acc_e              acc;
    logic [BYTE_W-1:0] hold_q;

    ctr_bridge_decode #(
        .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
    ) u_decode (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .acc(acc)
    );

    ctr_bridge_holdbyte u_hold (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
        .cnt_lo(cnt_value[BYTE_W-1:0]), .hold_q(hold_q)
    );

    ctr_bridge_reload u_reload (
        .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
        .hold_q(hold_q), .reload_q(reload_val), .reload_we(reload_we)
    );

    always_comb begin
        case (acc)
            ACC_RD_HI: bus_rdata = cnt_value[WORD_W-1:BYTE_W];
            ACC_RD_LO: bus_rdata = hold_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign cnt_hold = (acc == ACC_RD_HI);
endmodule

// File: rtl/ctr_byte_bridge_chk.sv
module ctr_byte_bridge_chk
    import ctr_byte_bridge_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int ADDR_HI = 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [BYTE_W-1:0]     bus_wdata,
    input logic [BYTE_W-1:0]     bus_rdata,
    input logic [WORD_W-1:0]     cnt_value,
    input logic [WORD_W-1:0]     reload_val,
    input logic                  reload_we,
    input logic                  cnt_hold
);
    logic hi_wr, hi_rd;
    assign hi_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_HI));
    assign hi_rd = bus_rd && !bus_wr && (bus_addr == ADDR_W'(ADDR_HI));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (reload_val == '0 && !reload_we));

    // R3
    hi_write_commit_chk: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (reload_we && reload_val[WORD_W-1:BYTE_W] == $past(bus_wdata)));

    // R3
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        reload_we |-> $past(hi_wr));

    // R4
    reload_only_on_hi_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(reload_val) |-> $past(hi_wr));

    // R5
    hi_read_data_chk: assert property (@(posedge clk) disable iff (rst)
        hi_rd |-> bus_rdata == cnt_value[WORD_W-1:BYTE_W]);

    // R7
    hold_match_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_hold == hi_rd);

    // R8
    wr_beats_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_rd) |-> (bus_rdata == '0 && !cnt_hold));
endmodule

bind ctr_byte_bridge ctr_byte_bridge_chk #(
    .ADDR_W(ADDR_W), .ADDR_HI(ADDR_HI)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_value(cnt_value),
    .reload_val(reload_val), .reload_we(reload_we), .cnt_hold(cnt_hold)
);

// File: tb/test_ctr_byte_bridge.sv
module test_ctr_byte_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] cnt_value = '0;
    logic [15:0] reload_val;
    logic        reload_we, cnt_hold;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [7:0]  m_hold;
    logic [15:0] m_reload;
    logic        m_we;

    always #5 clk = ~clk;

    ctr_byte_bridge i_ctr_byte_bridge (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_value(cnt_value),
        .reload_val(reload_val), .reload_we(reload_we), .cnt_hold(cnt_hold)
    );

    function automatic logic [7:0] exp_rdata(logic [1:0] a, logic w, logic r,
                                             logic [15:0] c, logic [7:0] h);
        if (w || !r) return 8'h00;
        if (a == 2'd1) return c[15:8];
        if (a == 2'd0) return h;
        return 8'h00;
    endfunction

    function automatic logic exp_hold(logic [1:0] a, logic w, logic r);
        return r && !w && a == 2'd1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op(logic [1:0] a, logic w, logic r, logic [7:0] d, logic [15:0] c,
                      string req);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; cnt_value = c;
        #1;
        check({req, " rdata"}, 32'(bus_rdata), 32'(exp_rdata(a, w, r, c, m_hold)));
        check({req, " hold"},  32'(cnt_hold),  32'(exp_hold(a, w, r)));
        m_we = w && a == 2'd1;
        if (m_we) m_reload = {d, m_hold};
        if (w && a == 2'd0) m_hold = d;
        else if (exp_hold(a, w, r)) m_hold = c[7:0];
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        check({req, " reload"}, 32'(reload_val), 32'(m_reload));
        check({req, " strobe"}, 32'(reload_we),  32'(m_we));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_hold = 8'h00; m_reload = 16'h0000; m_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        check("R1 reload", 32'(reload_val), 32'h0);
        check("R1 strobe", 32'(reload_we), 32'h0);
        // R6: holding byte reads 00h after reset
        op(2'd0, 0, 1, 8'h00, 16'hBEEF, "R6 lo read after reset");
        // R2: low write only touches holding byte
        op(2'd0, 1, 0, 8'h5A, 16'h0000, "R2 lo write");
        op(2'd0, 0, 1, 8'h00, 16'h1234, "R2 lo readback");
        // R3: high write commits both halves
        op(2'd1, 1, 0, 8'hC3, 16'h0000, "R3 hi write");
        op(2'd1, 1, 0, 8'h11, 16'h0000, "R3 back-to-back hi write");
        // R5 / R7: high read captures low byte
        op(2'd1, 0, 1, 8'h00, 16'hA1B2, "R5 hi read");
        // R6: low read returns captured byte while counter moved
        op(2'd0, 0, 1, 8'h00, 16'hA1FF, "R6 lo read captured");
        // R10: captured byte feeds next reload
        op(2'd1, 1, 0, 8'h77, 16'h0000, "R10 hi write after capture");
        // R8: simultaneous read and write
        op(2'd1, 1, 1, 8'h99, 16'hFEDC, "R8 wr+rd hi");
        op(2'd0, 1, 1, 8'h3C, 16'hFEDC, "R8 wr+rd lo");
        // R9: other addresses
        op(2'd2, 1, 0, 8'hEE, 16'h0000, "R9 wr addr2");
        op(2'd3, 0, 1, 8'h00, 16'h4321, "R9 rd addr3");
        op(2'd0, 0, 1, 8'h00, 16'h0000, "R9 hold unchanged");
        // R4: random mix, reload checked every cycle
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            op(rv[1:0], rv[2], rv[3], rv[11:4], rv[27:12], "R4 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule